// File: doc/BRIEF.md
# Programmable Down-Counting Event Timer

A single timer channel that sits on a plain 32-bit register bus and raises one level interrupt. Software stores a 64-bit reload value as two 32-bit words, then writes a small control word that turns the counter on, picks periodic or single-shot operation and gates the interrupt line. While enabled, the counter drops by one on every cycle in which the tick-enable input is high. The tick enable is a one-cycle strobe made elsewhere from a slower time base.

On a tick that finds the counter at zero, the timer expires. In periodic operation it reloads and keeps going, so a reload value of N-1 gives one expiry every N ticks. In single-shot operation it stays at zero and stays quiet until software restarts it. Each expiry sets a sticky pending flag, which software clears by writing a one. The 64-bit live count can be read back as two words at any time, so the block can also serve as a free-running time base with its interrupt masked. A parameter places the control word at one of two bus offsets.

Top module: `evt_timer`

## Requirements
- R1: After reset every readable location returns 0, the counter is stopped and `irq` is low.
- R2: The reload value is written and read back as a low word at offset 0x00 and a high word at 0x04. The live count reads as a low word at 0x08 and a high word at 0x0C. Any unmapped offset reads 0.
- R3: The control word sits at offset `CTRL_OFS` (0x10 by default, or 0x1C), with bit 0 = run, bit 1 = single-shot (0 = periodic), and bit 2 = interrupt unmask. Reads return those three bits. A write to the other candidate offset has no effect.
- R4: A control write that takes the run bit from 0 to 1 copies the 64-bit reload value into the counter. Reload-value writes made while running leave the live count alone until the next reload.
- R5: While running, the count falls by exactly one per cycle with `tick_en` high. When stopped, the count holds its value whatever `tick_en` does.
- R6: In periodic mode, a tick at count 0 expires and reloads the counter from the reload value, giving one expiry every reload+1 ticks.
- R7: In single-shot mode, a tick at count 0 expires once. The count then stays at 0 with no further expiry until the run bit is cleared and set again.
- R8: The pending flag is at offset 0x18, bit 0. It is set on the clock edge of an expiry whatever the mask. Writing 1 to bit 0 clears it, writing 0 has no effect, and an expiry on the same edge as a clear leaves it set.
- R9: `irq` is high exactly when the pending flag and the unmask bit are both set.
- R10: With a reload of low word 0xFFFFFFFF, high word 0 and the interrupt masked, the block runs as a plain down counter whose value reads back correctly and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle count strobe |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A bad count shows at the count read-back offsets on the next cycle after the faulty tick. It also shows as an expiry arriving one or more ticks early or late, so a bench that counts its own ticks sees a wrong pending flag within one reload period. A stuck or lost single-shot hold shows up as a second expiry after the flag is cleared. A wrong pending flag or mask bit shows on `irq` in the same cycle.

// File: rtl/etmr_pkg.sv
// Shared types and register offsets for the event timer.
// Assumes a byte-addressed bus with 32-bit aligned registers.
package etmr_pkg;
    typedef struct packed {
        logic unmask;   // bit 2
        logic oneshot;  // bit 1
        logic run;      // bit 0
    } ctrl_t;

    localparam int OFS_LOAD_LO = 'h00;
    localparam int OFS_CNT_LO  = 'h08;
    localparam int OFS_STATUS  = 'h18;
endpackage

// File: rtl/etmr_regs.sv
// Register file and bus decode of the event timer.
// Holds the two reload words and the control word, produces the start and
// clear strobes, and muxes read data. Assumes single-cycle writes.
module etmr_regs
    import etmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int CTRL_OFS = 'h10,
    localparam int CNT_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              status,
    output logic [CNT_W-1:0]  load_val,
    output ctrl_t             ctrl_q,
    output logic              start_p,
    output logic              clr_p
);
    logic ctrl_hit;

    // One register per reload word, each at its own offset.
    for (genvar w = 0; w < 2; w++) begin : g_ldw
        logic [DATA_W-1:0] word_q;
        // Capture a reload word on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (bus_we && bus_addr == ADDR_W'(OFS_LOAD_LO + 4 * w))
                word_q <= bus_wdata;
        end
        assign load_val[w*DATA_W +: DATA_W] = word_q;
    end

    assign ctrl_hit = bus_we && (bus_addr == ADDR_W'(CTRL_OFS));

    // Capture the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_hit)
            ctrl_q <= ctrl_t'(bus_wdata[2:0]);
    end

    // Start on a run bit rising edge; clear pending on write-one.
    assign start_p = ctrl_hit && bus_wdata[0] && !ctrl_q.run;
    assign clr_p   = bus_we && (bus_addr == ADDR_W'(OFS_STATUS)) && bus_wdata[0];

    // Read-data mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_LOAD_LO))
            bus_rdata = load_val[DATA_W-1:0];
        else if (bus_addr == ADDR_W'(OFS_LOAD_LO + 4))
            bus_rdata = load_val[CNT_W-1:DATA_W];
        else if (bus_addr == ADDR_W'(OFS_CNT_LO))
            bus_rdata = cnt_val[DATA_W-1:0];
        else if (bus_addr == ADDR_W'(OFS_CNT_LO + 4))
            bus_rdata = cnt_val[CNT_W-1:DATA_W];
        else if (bus_addr == ADDR_W'(CTRL_OFS))
            bus_rdata = DATA_W'(ctrl_q);
        else if (bus_addr == ADDR_W'(OFS_STATUS))
            bus_rdata = DATA_W'(status);
    end

    // R4: a start always leaves the run bit set.
    a_r4_start_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> ctrl_q.run);
endmodule

// File: rtl/etmr_core.sv
// Down counter of the event timer.
// Loads on start, decrements per tick while running, and reloads (periodic)
// or parks at zero (single-shot) on expiry. Assumes start only while stopped.
module etmr_core #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run,
    input  logic             oneshot,
    input  logic             start_p,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire_p
);
    logic done_q;
    logic at_zero;

    assign at_zero = (cnt_q == '0);

    // Expiry: a tick at zero, except after a single-shot has already fired.
    assign expire_p = run && tick_en && at_zero && !(oneshot && done_q);

    // Counter and single-shot done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (start_p) begin
            cnt_q  <= load_val;
            done_q <= 1'b0;
        end else if (run && tick_en) begin
            if (!at_zero)
                cnt_q <= cnt_q - 1'b1;
            else if (!oneshot)
                cnt_q <= load_val;
            else
                done_q <= 1'b1;
        end
    end

    // R4: start copies the reload value.
    a_r4_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> cnt_q == $past(load_val));
    // R5: one step down per tick.
    a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !at_zero) |=> cnt_q == $past(cnt_q) - 1'b1);
    // R5: stopped counter holds.
    a_r5_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start_p) |=> $stable(cnt_q));
    // R6: periodic reload at zero.
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !oneshot && tick_en && at_zero) |=> cnt_q == $past(load_val));
    // R7: single-shot parks at zero.
    a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
        (run && oneshot && at_zero) |=> cnt_q == '0);
endmodule

// File: rtl/etmr_flag.sv
// Sticky pending flag and interrupt gate of the event timer.
// Set wins over a clear in the same cycle.
module etmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_p,
    input  logic clr_p,
    input  logic unmask,
    output logic status_q,
    output logic irq
);
    // Pending flag: set on expiry, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= 1'b0;
        else if (expire_p)
            status_q <= 1'b1;
        else if (clr_p)
            status_q <= 1'b0;
    end

    assign irq = status_q && unmask;

    // R8: expiry always leaves the flag set.
    a_r8_set_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        expire_p |=> status_q);
    // R8: without a clear the flag stays.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !clr_p) |=> status_q);
endmodule

// File: rtl/evt_timer.sv
// Event timer top: register file, down counter and pending flag.
// Assumes tick_en is synchronous to clk; CTRL_OFS is 'h10 or 'h1C.
module evt_timer #(
    parameter int ADDR_W   = 8,
    parameter int CTRL_OFS = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    import etmr_pkg::*;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 2 * DATA_W;

    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_val;
    ctrl_t            ctrl_q;
    logic             start_p, clr_p, expire_p, status_q;

    etmr_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cnt_val(cnt_val), .status(status_q),
        .load_val(load_val), .ctrl_q(ctrl_q),
        .start_p(start_p), .clr_p(clr_p)
    );

    etmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .run(ctrl_q.run), .oneshot(ctrl_q.oneshot),
        .start_p(start_p), .load_val(load_val),
        .cnt_q(cnt_val), .expire_p(expire_p)
    );

    etmr_flag u_flag (
        .clk(clk), .rst_n(rst_n), .expire_p(expire_p), .clr_p(clr_p),
        .unmask(ctrl_q.unmask), .status_q(status_q), .irq(irq)
    );
endmodule

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        irq0, irq1;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    evt_timer #(.ADDR_W(8), .CTRL_OFS('h10)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rdata0), .irq(irq0));
    evt_timer #(.ADDR_W(8), .CTRL_OFS('h1C)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rdata1), .irq(irq1));

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk); bus_addr = a; #1; v = rdata0;
    endtask

    // Drive tick for n cycles (random or always high); return tick count.
    task automatic run(int n, bit rnd, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = rnd ? 1'($urandom % 2) : 1'b1;
            if (tick_en) k++;
        end
        @(negedge clk); tick_en = 1'b0;
    endtask

    // Expected count after k ticks from reload L.
    function automatic int exp_cnt(int l, int k, bit oneshot);
        if (oneshot) return (k > l) ? 0 : l - k;
        return l - (k % (l + 1));
    endfunction

    initial begin
        logic [31:0] v;
        int k;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 'h20; a += 4) begin
            rd(8'(a), v); chk("R1 reset read", v, 0);
        end
        chk("R1 irq low", irq0, 0);

        // R2: reload word read-back
        wr(8'h00, 32'hDEAD_BEEF); wr(8'h04, 32'h1234_5678);
        rd(8'h00, v); chk("R2 load lo", v, 32'hDEAD_BEEF);
        rd(8'h04, v); chk("R2 load hi", v, 32'h1234_5678);
        rd(8'h14, v); chk("R2 unmapped", v, 0);

        // R3: control word placement
        wr(8'h10, 32'hFFFF_FFFA); rd(8'h10, v); chk("R3 ctrl bits", v, 32'h2);
        rd(8'h1C, v); chk("R3 other offset", v, 0);
        wr(8'h1C, 32'h5);
        @(negedge clk); bus_addr = 8'h1C; #1; chk("R3 alt offset ctrl", rdata1, 32'h5);
        bus_addr = 8'h10; #1; chk("R3 alt other offset", rdata1, 0);
        rd(8'h10, v); chk("R3 no effect on main", v, 32'h2);
        wr(8'h1C, 32'h0); wr(8'h10, 32'h0);

        // R4: start loads 64 bits; loads while running ignored until reload
        rd(8'h08, v); chk("R4 stopped count", v, 0);
        wr(8'h10, 32'h1);
        rd(8'h08, v); chk("R4 start lo", v, 32'hDEAD_BEEF);
        rd(8'h0C, v); chk("R4 start hi", v, 32'h1234_5678);
        wr(8'h10, 0); wr(8'h04, 0); wr(8'h00, 10); wr(8'h18, 1);
        wr(8'h10, 32'h1);
        run(2, 0, k);
        wr(8'h00, 3);
        rd(8'h08, v); chk("R4 load while running", v, 8);
        // R6: reload on the tick at zero
        run(9, 0, k);
        rd(8'h08, v); chk("R6 reload new value", v, 3);
        rd(8'h18, v); chk("R6 expiry flag", v, 1);
        chk("R9 masked irq", irq0, 0);
        wr(8'h10, 32'h4);
        chk("R9 unmask pending", irq0, 1);

        // R8: write 0 no effect, write 1 clears, set wins
        wr(8'h18, 0); rd(8'h18, v); chk("R8 write zero", v, 1);
        wr(8'h18, 1); rd(8'h18, v); chk("R8 clear", v, 0);
        chk("R9 irq follows clear", irq0, 0);
        wr(8'h10, 0); wr(8'h00, 0); wr(8'h10, 32'h1);
        @(negedge clk); tick_en = 1'b1;
        wr(8'h18, 1);
        tick_en = 1'b0;
        rd(8'h18, v); chk("R8 set wins", v, 1);
        wr(8'h18, 1); rd(8'h18, v); chk("R8 clear idle", v, 0);

        // R7: single-shot
        wr(8'h10, 0); wr(8'h00, 4); wr(8'h10, 32'h7);
        run(5, 0, k);
        rd(8'h08, v); chk("R7 at zero", v, 0);
        chk("R7 irq", irq0, 1);
        wr(8'h18, 1);
        run(6, 0, k);
        rd(8'h08, v); chk("R7 holds zero", v, 0);
        rd(8'h18, v); chk("R7 no second expiry", v, 0);
        wr(8'h10, 0); wr(8'h10, 32'h3);
        rd(8'h08, v); chk("R7 restart", v, 4);

        // R5: stopped counter ignores ticks
        run(2, 0, k);
        wr(8'h10, 0);
        run(5, 0, k);
        rd(8'h08, v); chk("R5 stopped hold", v, 2);

        // R10: free-running time base, masked
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 0); wr(8'h10, 32'h1);
        run(50, 1, k);
        rd(8'h08, v); chk("R10 lo", v, 32'hFFFF_FFFF - k);
        rd(8'h0C, v); chk("R10 hi", v, 0);
        chk("R10 irq low", irq0, 0);

        // R5 R6 R7 R8 R9: random reloads, modes and tick patterns
        for (int it = 0; it < 40; it++) begin
            int l = $urandom % 12;
            bit os = 1'($urandom % 2);
            bit um = 1'($urandom % 2);
            wr(8'h10, 0); wr(8'h18, 1); wr(8'h00, l); wr(8'h04, 0);
            wr(8'h10, {29'b0, um, os, 1'b1});
            run($urandom % 40, 1, k);
            rd(8'h08, v); chk("R5 random count", v, exp_cnt(l, k, os));
            rd(8'h18, v); chk("R8 random flag", v, (k > l) ? 1 : 0);
            chk("R9 random irq", irq0, ((k > l) && um) ? 1 : 0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule